// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between an on-chip valid/ready request bus and an external asynchronous static RAM with 131,072 words of 16 bits. It accepts one single-word read or write at a time and turns it into chip, write, output and per-byte lane enable strobes for the RAM. All of these strobes are active low. Each timing interval is held for a parameterised number of system clocks. The defaults are the 70 ns device minimums rounded up to whole cycles of a 100 MHz clock.

A read keeps the chip and output enables low for the access count and captures the data on the last access edge. The data is then returned with a one-cycle response pulse. Lanes the request masked off come back as zero. A write first spends one setup cycle with the address already stable. It then holds write enable low for the pulse count and releases it while the address and chip enable stay put. The controller keeps driving the data for one clock after write enable rises. A write that follows a read waits through a turnaround gap, so the RAM can release the bus first. The pad buffers sit outside this block. It exposes separate data-out, data-in and data-drive-enable signals.

Top module: `async_sram_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is in progress, the chip, write and output enables are high, both lane enables are high (sram_be_n = 2'b11), sram_dout_en is low and req_ready is high.
- R2: A read holds sram_ce_n and sram_oe_n low and sram_we_n high for exactly READ_CYC cycles (default 7), counted from the accepting clock edge. During this window sram_addr equals the accepted req_addr.
- R3: Read data is captured on the edge that ends the access window. rsp_valid is high for exactly one cycle, READ_CYC cycles after acceptance. In rsp_rdata, bits 7:0 come back only if req_be_n[0] was 0 and bits 15:8 only if req_be_n[1] was 0. Any masked lane reads as zero.
- R4: A write takes one setup cycle with sram_ce_n low and sram_we_n high. The pulse then holds sram_we_n low for max(WPULSE_CYC, DSETUP_CYC) cycles (default 4). The recovery that follows keeps sram_ce_n low with sram_we_n high, and the whole chip-enable window lasts at least WCYCLE_CYC cycles (default 7).
- R5: sram_addr does not change while sram_ce_n stays low, so the address is stable before write enable falls and until after it rises.
- R6: sram_dout_en is high only while sram_we_n is low and for the one cycle after it rises, and sram_dout holds the write data across that cycle. sram_oe_n stays high during the whole write.
- R7: A write drives sram_be_n with the accepted req_be_n, so only lanes with a 0 mask bit change. A write with req_be_n = 2'b11 leaves the word unchanged.
- R8: A write accepted after a read waits TURN_CYC extra cycles (default 3) with the chip deselected before its setup cycle. Its response comes WCYCLE_CYC + TURN_CYC cycles after acceptance (default 10); otherwise it comes WCYCLE_CYC cycles after acceptance.
- R9: Every accepted write produces exactly one rsp_valid pulse, one cycle after its last recovery cycle.
- R10: req_ready is low from the accepting edge until the response cycle, and a request held valid in that time is not accepted.
- R11: sram_dout_en and an active (low) sram_oe_n are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be_n | input | 2 | Active-low lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion pulse for reads and writes |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| sram_addr | output | 17 | RAM address |
| sram_dout | output | 16 | Data toward the RAM |
| sram_dout_en | output | 1 | Enable for the external data drivers |
| sram_din | input | 16 | Data from the RAM |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Lane enables, active low |

## Verification
The hardest situation to provoke is a turnaround: a write must arrive right after a read's output enable has gone high, while the previous read is still in flight. The driver holds req_valid high across back-to-back requests, including read-then-write, read-then-read-then-write and write-then-write chains, so the accepting edge falls in the first idle cycle. The bench's RAM model refuses to return valid data until the full access count has elapsed. It also checks pulse width, data hold and address stability, so a cycle shaved off any phase shows up as bad read data or a timing complaint.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_ACCESS,
    ST_WRITE_SETUP,
    ST_WRITE_PULSE,
    ST_WRITE_RECOVER,
    ST_TURNAROUND
  } sramcState_t;

  // Level strobes toward the pins, registered in the control.
  typedef struct packed {
    logic ceOn;
    logic weOn;
    logic oeOn;
    logic dataDrive;
  } sramcPins_t;

  // Full strobe bundle from control to datapath.
  typedef struct packed {
    sramcPins_t pins;
    logic       load;     // latch the request fields
    logic       capture;  // sample read data this edge
    logic       done;     // access finishes this edge
  } sramcStrobe_t;

endpackage

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int READ_CYC    = 7,
  parameter int PULSE_CYC   = 4,
  parameter int RECOVER_CYC = 2,
  parameter int TURN_CYC    = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output sramcStrobe_t stb
);

  localparam int MAX_A   = (READ_CYC > PULSE_CYC) ? READ_CYC : PULSE_CYC;
  localparam int MAX_B   = (RECOVER_CYC > TURN_CYC) ? RECOVER_CYC : TURN_CYC;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t READ_LAST    = cnt_t'(READ_CYC - 1);
  localparam cnt_t PULSE_LAST   = cnt_t'(PULSE_CYC - 1);
  localparam cnt_t RECOVER_LAST = cnt_t'(RECOVER_CYC - 1);
  localparam cnt_t TURN_LAST    = cnt_t'(TURN_CYC - 1);

  sramcState_t state, stateNext;
  cnt_t        cnt, cntNext;
  logic        lastRead, lastReadNext;
  logic        load, capture, done;
  sramcPins_t  pinsQ;

  function automatic sramcPins_t decodePins(sramcState_t s, cnt_t c);
    sramcPins_t p;
    p.ceOn      = (s == ST_READ_ACCESS) || (s == ST_WRITE_SETUP) ||
                  (s == ST_WRITE_PULSE) || (s == ST_WRITE_RECOVER);
    p.weOn      = (s == ST_WRITE_PULSE);
    p.oeOn      = (s == ST_READ_ACCESS);
    p.dataDrive = (s == ST_WRITE_PULSE) ||
                  ((s == ST_WRITE_RECOVER) && (c == RECOVER_LAST));
    return p;
  endfunction

  always_comb begin
    stateNext    = state;
    cntNext      = cnt;
    lastReadNext = lastRead;
    load         = 1'b0;
    capture      = 1'b0;
    done         = 1'b0;
    reqReady     = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          load = 1'b1;
          if (reqWrite) begin
            if (lastRead) begin
              stateNext = ST_TURNAROUND;
              cntNext   = TURN_LAST;
            end else begin
              stateNext = ST_WRITE_SETUP;
            end
          end else begin
            stateNext = ST_READ_ACCESS;
            cntNext   = READ_LAST;
          end
        end
      end
      ST_READ_ACCESS: begin
        if (cnt == '0) begin
          capture      = 1'b1;
          done         = 1'b1;
          lastReadNext = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          cntNext = cnt - cnt_t'(1);
        end
      end
      ST_TURNAROUND: begin
        if (cnt == '0) stateNext = ST_WRITE_SETUP;
        else           cntNext   = cnt - cnt_t'(1);
      end
      ST_WRITE_SETUP: begin
        lastReadNext = 1'b0;
        stateNext    = ST_WRITE_PULSE;
        cntNext      = PULSE_LAST;
      end
      ST_WRITE_PULSE: begin
        if (cnt == '0) begin
          stateNext = ST_WRITE_RECOVER;
          cntNext   = RECOVER_LAST;
        end else begin
          cntNext = cnt - cnt_t'(1);
        end
      end
      ST_WRITE_RECOVER: begin
        if (cnt == '0) begin
          done      = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          cntNext = cnt - cnt_t'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
      pinsQ    <= '0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      lastRead <= lastReadNext;
      pinsQ    <= decodePins(stateNext, cntNext);
    end
  end

  assign stb.pins    = pinsQ;
  assign stb.load    = load;
  assign stb.capture = capture;
  assign stb.done    = done;

  // R10
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8
  turn_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TURNAROUND) |-> !pinsQ.ceOn && !pinsQ.dataDrive);

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sramcStrobe_t          stb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqBeN,
  input  logic [DATA_W-1:0]     sramDin,
  output logic [ADDR_W-1:0]     sramAddr,
  output logic [DATA_W-1:0]     sramDout,
  output logic                  sramDoutEn,
  output logic                  sramCeN,
  output logic                  sramWeN,
  output logic                  sramOeN,
  output logic [DATA_W/8-1:0]   sramBeN,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspRdata
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beNQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beNQ   <= '1;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= stb.done;
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beNQ   <= reqBeN;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            rdataQ[l*8 +: 8] <= '0;
      else if (stb.capture) rdataQ[l*8 +: 8] <= beNQ[l] ? 8'h00 : sramDin[l*8 +: 8];
    end
  end

  assign sramAddr   = addrQ;
  assign sramDout   = wdataQ;
  assign sramDoutEn = stb.pins.dataDrive;
  assign sramCeN    = ~stb.pins.ceOn;
  assign sramWeN    = ~stb.pins.weOn;
  assign sramOeN    = ~stb.pins.oeOn;
  assign sramBeN    = stb.pins.ceOn ? beNQ : '1;
  assign rspValid   = rspQ;
  assign rspRdata   = rdataQ;

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> ($past(!sramCeN) && $stable(sramAddr)));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (sramDoutEn && $stable(sramDout) && !sramCeN));

  // R11
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sramDoutEn && !sramOeN));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 16,
  parameter int READ_CYC   = 7,
  parameter int WPULSE_CYC = 4,
  parameter int DSETUP_CYC = 3,
  parameter int WCYCLE_CYC = 7,
  parameter int TURN_CYC   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be_n,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic [DATA_W-1:0]   sram_dout,
  output logic                sram_dout_en,
  input  logic [DATA_W-1:0]   sram_din,
  output logic                sram_ce_n,
  output logic                sram_we_n,
  output logic                sram_oe_n,
  output logic [DATA_W/8-1:0] sram_be_n
);

  localparam int PULSE_CYC   = (WPULSE_CYC > DSETUP_CYC) ? WPULSE_CYC : DSETUP_CYC;
  localparam int RECOVER_CYC = (WCYCLE_CYC > PULSE_CYC + 2) ? (WCYCLE_CYC - 1 - PULSE_CYC) : 1;

  sramcStrobe_t stb;

  sramc_fsm #(
    .READ_CYC   (READ_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .RECOVER_CYC(RECOVER_CYC),
    .TURN_CYC   (TURN_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rst_n),
    .reqValid(req_valid),
    .reqWrite(req_write),
    .reqReady(req_ready),
    .stb     (stb)
  );

  sramc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uData (
    .clk       (clk),
    .rstN      (rst_n),
    .stb       (stb),
    .reqAddr   (req_addr),
    .reqWdata  (req_wdata),
    .reqBeN    (req_be_n),
    .sramDin   (sram_din),
    .sramAddr  (sram_addr),
    .sramDout  (sram_dout),
    .sramDoutEn(sram_dout_en),
    .sramCeN   (sram_ce_n),
    .sramWeN   (sram_we_n),
    .sramOeN   (sram_oe_n),
    .sramBeN   (sram_be_n),
    .rspValid  (rsp_valid),
    .rspRdata  (rsp_rdata)
  );

  // R6
  we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dout_en));

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dout_en));

endmodule

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;

  localparam int RD_LAT = 7;
  localparam int WR_LAT = 7;
  localparam int TA_CYC = 3;
  localparam int PULSE  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be_n = 2'b11;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic [15:0] sram_dout;
  logic        sram_dout_en;
  logic [15:0] dinQ = '0;
  logic        sram_ce_n, sram_we_n, sram_oe_n;
  logic [1:0]  sram_be_n;

  async_sram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be_n(req_be_n), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_dout(sram_dout), .sram_dout_en(sram_dout_en),
    .sram_din(dinQ), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int failed = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] initWord(input logic [16:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ {7'h0, a[16]} ^ 8'hC3};
  endfunction

  // RAM model storage and independent shadow storage
  logic [15:0] ramMem [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] ramRead(input logic [16:0] a);
    return ramMem.exists(int'(a)) ? ramMem[int'(a)] : initWord(a);
  endfunction

  function automatic logic [15:0] shadowRead(input logic [16:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : initWord(a);
  endfunction

  // Behavioural RAM with timing checks
  int          readRun = 0, weRun = 0, ceRun = 0;
  bit          ceWasLow = 0, weWasLow = 0, sawWrite = 0;
  logic [16:0] ceAddr;
  logic [15:0] wData;

  always @(negedge clk) begin
    if (rst_n) begin
      // R11
      chk(!(sram_dout_en && !sram_oe_n), "R11 contention", {sram_dout_en, sram_oe_n}, 2'b01);
      if (!sram_ce_n) begin
        ceRun++;
        if (!ceWasLow) ceAddr = sram_addr;
        else chk(sram_addr == ceAddr, "R5 address moved", sram_addr, ceAddr);
      end else if (ceWasLow) begin
        if (sawWrite) chk(ceRun >= WR_LAT, "R4 write cycle length", ceRun, WR_LAT);
        else          chk(ceRun == RD_LAT, "R2 read window", ceRun, RD_LAT);
        ceRun = 0;
        sawWrite = 0;
      end
      if (!sram_ce_n && !sram_oe_n && sram_we_n) readRun++;
      else readRun = 0;
      if (!sram_we_n) begin
        if (!weWasLow) chk(ceWasLow, "R4 setup cycle before pulse", ceWasLow, 1);
        sawWrite = 1;
        weRun++;
        wData = sram_dout;
        chk(sram_dout_en && sram_oe_n, "R6 drive during pulse", {sram_dout_en, sram_oe_n}, 2'b11);
      end else if (weWasLow) begin
        chk(weRun == PULSE, "R4 pulse width", weRun, PULSE);
        chk(sram_dout_en && sram_dout == wData, "R6 data hold", sram_dout, wData);
        chk(!sram_ce_n, "R4 recovery keeps chip enabled", sram_ce_n, 0);
        begin
          logic [15:0] w;
          w = ramRead(sram_addr);
          if (!sram_be_n[0]) w[7:0]  = wData[7:0];
          if (!sram_be_n[1]) w[15:8] = wData[15:8];
          ramMem[int'(sram_addr)] = w;
        end
        weRun = 0;
      end else begin
        chk(!sram_dout_en || sram_ce_n == 1'b0, "R6 stray drive", sram_dout_en, 0);
      end
      ceWasLow = !sram_ce_n;
      weWasLow = !sram_we_n;
      begin
        logic [15:0] m;
        m = ramRead(sram_addr);
        for (int l = 0; l < 2; l++)
          dinQ[l*8 +: 8] = (sram_be_n[l] || readRun < RD_LAT) ? 8'hA5 : m[l*8 +: 8];
      end
    end
  end

  // Scoreboard
  typedef struct {
    bit          isWrite;
    logic [15:0] exp;
    int          lat;
    int          acc;
    string       tag;
  } item_t;

  item_t expQ[$];
  bit    outstanding = 0;
  bit    prevRead = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        outstanding = 0;
        if (expQ.size() == 0) begin
          chk(0, "R9 unexpected response", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          chk(cyc - it.acc == it.lat, it.isWrite ? "R8 write latency" : "R3 read latency",
              cyc - it.acc, it.lat);
          if (!it.isWrite) chk(rsp_rdata == it.exp, it.tag, rsp_rdata, it.exp);
        end
      end else if (outstanding) begin
        // R10
        chk(!req_ready, "R10 ready while busy", req_ready, 0);
      end
    end
  end

  // Driver: call at a negedge; returns at the negedge after acceptance
  task automatic doReq(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
    item_t it;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_be_n  = be;
    while (!req_ready) @(negedge clk);
    it.isWrite = wr;
    it.acc     = cyc + 1;
    it.tag     = tag;
    it.lat     = wr ? (prevRead ? WR_LAT + TA_CYC : WR_LAT) : RD_LAT;
    if (wr) begin
      logic [15:0] w;
      w = shadowRead(a);
      if (!be[0]) w[7:0]  = d[7:0];
      if (!be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
      it.exp = '0;
    end else begin
      logic [15:0] s;
      s = shadowRead(a);
      it.exp = {be[1] ? 8'h00 : s[15:8], be[0] ? 8'h00 : s[7:0]};
    end
    prevRead = !wr;
    expQ.push_back(it);
    @(negedge clk);
    outstanding = 1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expQ.size() != 0 || outstanding) && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idleCheck(input string tag);
    chk(sram_ce_n && sram_we_n && sram_oe_n, tag, {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
    chk(sram_be_n == 2'b11 && !sram_dout_en, tag, {sram_be_n, sram_dout_en}, 3'b110);
    chk(req_ready && !rsp_valid, tag, {req_ready, rsp_valid}, 2'b10);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 20000);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    idleCheck("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    idleCheck("R1 after reset");

    // Full-word write and read, including top address
    doReq(1, 17'h00010, 16'h1234, 2'b00, "R7 write");
    doReq(0, 17'h00010, 16'h0, 2'b00, "R3 full read");
    doReq(1, 17'h1FFFF, 16'hABCD, 2'b00, "R7 write top");
    doReq(0, 17'h1FFFF, 16'h0, 2'b00, "R3 read top address");
    doReq(0, 17'h00555, 16'h0, 2'b00, "R3 read unwritten word");

    // Byte-masked writes (R7), including a fully masked one
    doReq(1, 17'h00020, 16'hFFFF, 2'b00, "R7 write");
    doReq(1, 17'h00020, 16'h0011, 2'b10, "R7 lower lane write");
    doReq(0, 17'h00020, 16'h0, 2'b00, "R7 lower lane only");
    doReq(1, 17'h00020, 16'h2200, 2'b01, "R7 upper lane write");
    doReq(0, 17'h00020, 16'h0, 2'b00, "R7 upper lane only");
    doReq(1, 17'h00020, 16'h9999, 2'b11, "R7 masked write");
    doReq(0, 17'h00020, 16'h0, 2'b00, "R7 fully masked write ignored");

    // Masked reads: disabled lane must read zero (R3)
    doReq(0, 17'h00020, 16'h0, 2'b10, "R3 lower lane read");
    doReq(0, 17'h00020, 16'h0, 2'b01, "R3 upper lane read");
    doReq(0, 17'h00020, 16'h0, 2'b11, "R3 no lane read");

    // Turnaround orderings (R8): read-read-write, write-write
    doReq(0, 17'h00030, 16'h0, 2'b00, "R3 read before turnaround");
    doReq(1, 17'h00030, 16'h5AA5, 2'b00, "R8 write after read");
    doReq(1, 17'h00031, 16'hC33C, 2'b00, "R8 write after write");
    doReq(0, 17'h00030, 16'h0, 2'b00, "R8 data after turnaround");
    doReq(0, 17'h00031, 16'h0, 2'b00, "R3 read after read");

    // Mixed traffic over a small window of addresses
    for (int i = 0; i < 40; i++) begin
      logic [16:0] a;
      logic [15:0] d;
      a = 17'(((i * 7) ^ (i >> 2)) & 15) | 17'h10000;
      d = 16'(i * 16'h1357 + 16'h2468);
      doReq(((i % 3) != 1), a, d, 2'((i * 5) % 4), "R3 mixed read");
    end

    drain();
    @(negedge clk);
    idleCheck("R1 idle after traffic");
    chk(expQ.size() == 0, "R9 missing response", expQ.size(), 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule